// File: doc/BRIEF.md
# Key-Serviced Software Watchdog

This block is a software watchdog. A down counter is loaded with a 16-bit timeout value, and it expires unless software services it in time. Servicing takes two writes to a service register, and they must arrive in order: a first key word and then a second key word. Only the completed pair reloads the counter. The counter can be stopped in three ways. Software can switch it off, the debug logic can freeze it when freezing is selected, and an optional divide-by-2048 prescaler can slow its step rate.

When the counter expires, the block raises a one-clock request. A select input chooses where the request goes: the nonmaskable interrupt line or the system reset request line. After expiry the counter reloads from the timeout value and keeps running. Another register block owns the control bits and passes them in as level inputs. The core handles the interrupt, and the reset controller acts on the reset request.

Top module: `svc_wdog_top`

## Requirements
- R1: A write of 0x556C followed by a write of 0xAA93 to the service register loads the counter with `timeout_i` and clears the prescaler. Other cycles may come between the two writes. The pair is accepted whether the watchdog is enabled or not.
- R2: A write that breaks the order returns the key checker to waiting for 0x556C and reloads nothing. This covers any value other than 0x556C as the first key and any value other than 0xAA93 as the second. For example, 0x556C, 0x556C, 0xAA93 does not service.
- R3: `svc_rdata_o` always reads as zero, including while a write is in progress.
- R4: While `wd_en_i` is 0, the counter holds its value and neither request output pulses.
- R5: While `frz_sel_i` is 1 and `dbg_freeze_i` is 1, the counter and the prescaler hold. When `frz_sel_i` is 0, `dbg_freeze_i` has no effect.
- R6: With `pre_sel_i` at 0, the counter steps once per clock. With `pre_sel_i` at 1, it steps once every 2048 clocks.
- R7: The step taken while the counter is zero is an expiry. After a load with value T, the first expiry comes T+1 steps later, and each further expiry comes T+1 steps after the one before. Each expiry produces a request pulse exactly one clock wide.
- R8: On expiry, `nmi_req_o` pulses if `exp_rst_sel_i` is 0 and `rst_req_o` pulses if it is 1. The two outputs never pulse together.
- R9: Reset sets the counter to 0xFFFF, sets the key checker to wait for the first key, and sets both outputs low. With no service, the first expiry comes 65536 steps after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wd_en_i | input | 1 | Watchdog enable (1 = counting) |
| frz_sel_i | input | 1 | 1 = honour the debug freeze input |
| dbg_freeze_i | input | 1 | Freeze indication from debug logic |
| exp_rst_sel_i | input | 1 | Expiry action: 0 = interrupt, 1 = reset request |
| pre_sel_i | input | 1 | 1 = step once per 2048 clocks |
| timeout_i | input | 16 | Value loaded on service and after expiry |
| svc_wr_i | input | 1 | Write strobe for the service register |
| svc_wdata_i | input | 16 | Write data for the service register |
| svc_rdata_o | output | 16 | Read data of the service register (always zero) |
| nmi_req_o | output | 1 | One-clock nonmaskable interrupt request |
| rst_req_o | output | 1 | One-clock system reset request |

## Verification
On every cycle, the bound checker enforces these properties:
- A completed key pair loads the counter with the timeout value.
- The count holds while the watchdog is disabled or frozen.
- Without the prescaler, the counter drops by one per active clock.
- Every pulse appears on the line that the select input picked, and the two lines never pulse together.
- Every pulse coincides with a reload from the timeout value.

Some behaviours span thousands of cycles or depend on a chain of writes, so only the bench scenarios can show them:
- the 65536-step first expiry after reset;
- the 2048-clock prescaled period;
- that broken key orders leave the original expiry time unchanged;
- that a pair written while disabled takes effect once counting resumes.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic {
        KEY_WAIT_FIRST  = 1'b0,
        KEY_WAIT_SECOND = 1'b1
    } key_state_e;

    typedef struct packed {
        key_state_e st;
    } key_regs_t;

endpackage

// File: rtl/swd_key_seq.sv
module swd_key_seq
    import swd_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter logic [15:0] KEY_FIRST  = 16'h556C,
    parameter logic [15:0] KEY_SECOND = 16'hAA93
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              reload_o
);

    localparam logic [DATA_W-1:0] FIRST_V  = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] SECOND_V = DATA_W'(KEY_SECOND);

    key_regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        reload_o = 1'b0;
        if (wr_i) begin
            unique case (regs_q.st)
                KEY_WAIT_FIRST: begin
                    regs_d.st = (wdata_i == FIRST_V) ? KEY_WAIT_SECOND : KEY_WAIT_FIRST;
                end
                KEY_WAIT_SECOND: begin
                    reload_o  = (wdata_i == SECOND_V);
                    regs_d.st = KEY_WAIT_FIRST;
                end
                default: regs_d.st = KEY_WAIT_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.st <= KEY_WAIT_FIRST;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
    parameter int PRE_W = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic div_en_i,
    input  logic clr_i,
    output logic step_o
);

    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_regs_t;

    pre_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        step_o = 1'b0;
        if (clr_i) begin
            regs_d.div = '0;
        end else if (run_i) begin
            if (div_en_i) begin
                regs_d.div = regs_q.div + 1'b1;
                step_o     = (regs_q.div == PRE_LAST);
            end else begin
                step_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.div <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             rst_sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             nmi_o,
    output logic             rst_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             nmi;
        logic             rst;
    } cnt_regs_t;

    cnt_regs_t regs_d, regs_q;
    logic      expire;

    always_comb begin
        regs_d     = regs_q;
        expire     = 1'b0;
        regs_d.nmi = 1'b0;
        regs_d.rst = 1'b0;
        if (load_i) begin
            regs_d.cnt = load_val_i;
        end else if (step_i) begin
            if (regs_q.cnt == '0) begin
                expire     = 1'b1;
                regs_d.cnt = load_val_i;
            end else begin
                regs_d.cnt = regs_q.cnt - 1'b1;
            end
        end
        regs_d.nmi = expire && !rst_sel_i;
        regs_d.rst = expire &&  rst_sel_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.cnt <= '1;
            regs_q.nmi <= 1'b0;
            regs_q.rst <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cnt_o = regs_q.cnt;
    assign nmi_o = regs_q.nmi;
    assign rst_o = regs_q.rst;

endmodule

// File: rtl/svc_wdog_top.sv
module svc_wdog_top #(
    parameter int          CNT_W      = 16,
    parameter int          DATA_W     = 16,
    parameter int          PRE_W      = 11,
    parameter logic [15:0] KEY_FIRST  = 16'h556C,
    parameter logic [15:0] KEY_SECOND = 16'hAA93
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wd_en_i,
    input  logic              frz_sel_i,
    input  logic              dbg_freeze_i,
    input  logic              exp_rst_sel_i,
    input  logic              pre_sel_i,
    input  logic [CNT_W-1:0]  timeout_i,
    input  logic              svc_wr_i,
    input  logic [DATA_W-1:0] svc_wdata_i,
    output logic [DATA_W-1:0] svc_rdata_o,
    output logic              nmi_req_o,
    output logic              rst_req_o
);

    logic             reload_w;
    logic             run_w;
    logic             step_w;
    logic [CNT_W-1:0] cnt_w;

    assign run_w       = wd_en_i && !(frz_sel_i && dbg_freeze_i);
    assign svc_rdata_o = '0;

    swd_key_seq #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_keys (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (svc_wr_i),
        .wdata_i (svc_wdata_i),
        .reload_o(reload_w)
    );

    swd_prescaler #(
        .PRE_W(PRE_W)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_w),
        .div_en_i(pre_sel_i),
        .clr_i   (reload_w),
        .step_o  (step_w)
    );

    swd_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step_w),
        .load_i    (reload_w),
        .load_val_i(timeout_i),
        .rst_sel_i (exp_rst_sel_i),
        .cnt_o     (cnt_w),
        .nmi_o     (nmi_req_o),
        .rst_o     (rst_req_o)
    );

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en,
    input logic             fsel,
    input logic             frz,
    input logic             psel,
    input logic             rsel,
    input logic [CNT_W-1:0] tmo,
    input logic             reload,
    input logic [CNT_W-1:0] cnt,
    input logic             nmi,
    input logic             rst
);

    AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload |=> cnt == $past(tmo)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !reload) |=> $stable(cnt)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en |=> (!nmi && !rst)); // R4

    AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsel && frz && !reload) |=> $stable(cnt)); // R5

    AST_FAST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && !(fsel && frz) && !psel && !reload && cnt != '0)
        |=> cnt == $past(cnt) - 1'b1); // R6

    AST_EXPIRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi || rst) |-> cnt == $past(tmo)); // R7

    AST_NMI_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi |-> $past(!rsel)); // R8

    AST_RST_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst |-> $past(rsel)); // R8

    AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(nmi && rst)); // R8

endmodule

bind svc_wdog_top swd_checker u_swd_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en    (wd_en_i),
    .fsel  (frz_sel_i),
    .frz   (dbg_freeze_i),
    .psel  (pre_sel_i),
    .rsel  (exp_rst_sel_i),
    .tmo   (timeout_i),
    .reload(reload_w),
    .cnt   (cnt_w),
    .nmi   (nmi_req_o),
    .rst   (rst_req_o)
);

// File: tb/test_svc_wdog_top.sv
module test_svc_wdog_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1, fsel = 1'b0, frz = 1'b0, rsel = 1'b0, psel = 1'b0;
    logic [15:0] tmo = 16'd5;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        nmi, rstq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R9";

    // bench model state, built from the requirements
    bit          m_wait2 = 1'b0;
    logic [15:0] m_cnt = 16'hFFFF;
    logic [10:0] m_pre = '0;
    bit          m_nmi = 1'b0, m_rst = 1'b0;

    always #5 clk = ~clk;

    svc_wdog_top i_svc_wdog_top (
        .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en), .frz_sel_i(fsel),
        .dbg_freeze_i(frz), .exp_rst_sel_i(rsel), .pre_sel_i(psel),
        .timeout_i(tmo), .svc_wr_i(wr), .svc_wdata_i(wdata),
        .svc_rdata_o(rdata), .nmi_req_o(nmi), .rst_req_o(rstq)
    );

    function automatic int exp_gap(input int t, input bit ps);
        return ps ? 2048 * (t + 1) : t + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        bit act, stp, rl, ex;
        if (!rst_n) begin
            m_wait2 = 0; m_cnt = 16'hFFFF; m_pre = '0; m_nmi = 0; m_rst = 0;
        end else begin
            rl  = wr && m_wait2 && (wdata == 16'hAA93);
            if (wr) m_wait2 = !m_wait2 && (wdata == 16'h556C);
            act = en && !(fsel && frz);
            stp = act && (!psel || m_pre == 11'h7FF);
            ex  = !rl && stp && (m_cnt == 16'd0);
            m_nmi = ex && !rsel;
            m_rst = ex && rsel;
            if (rl) begin
                m_cnt = tmo; m_pre = '0;
            end else begin
                if (act && psel) m_pre = m_pre + 1'b1;
                if (stp) m_cnt = (m_cnt == 16'd0) ? tmo : m_cnt - 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(nmi == m_nmi, {cur_req, " nmi"}, int'(nmi), int'(m_nmi));
            chk(rstq == m_rst, {cur_req, " rst"}, int'(rstq), int'(m_rst));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chk(1'b0, "watchdog", cyc, 190000);
            finish_run();
        end
    end

    task automatic wr_key(input logic [15:0] v);
        @(negedge clk);
        wr = 1'b1; wdata = v;
        #1;
        chk(rdata == 16'h0, "R3 rdata during write", int'(rdata), 0);
        @(negedge clk);
        wr = 1'b0;
        chk(rdata == 16'h0, "R3 rdata after write", int'(rdata), 0);
    endtask

    task automatic service();
        wr_key(16'h556C);
        wr_key(16'hAA93);
    endtask

    task automatic measure(output int n, input int lim);
        n = 0;
        while (!(nmi || rstq) && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_pulses(output int p, input int ncyc);
        p = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (nmi || rstq) p++;
        end
    endtask

    initial begin
        int n, p;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(nmi == 0 && rstq == 0, "R9 outputs in reset", int'(nmi | rstq), 0);
        rst_n = 1'b1;
        chk(rdata == 0, "R9 rdata after reset", int'(rdata), 0);

        // R9: first expiry 65536 steps after release
        measure(n, 70000);
        chk(n == 65536, "R9 first expiry", n, 65536);

        // R1/R7: service and period
        cur_req = "R7";
        tmo = 16'd5;
        service();
        measure(n, 100);
        chk(n == exp_gap(5, 0), "R1 delay after service", n, exp_gap(5, 0));
        chk(nmi == 1 && rstq == 0, "R8 nmi mode", int'(nmi), 1);
        @(negedge clk);
        chk(nmi == 0, "R7 pulse width", int'(nmi), 0);
        measure(n, 100);
        chk(n == exp_gap(5, 0) - 1, "R7 repeat period", n, exp_gap(5, 0) - 1);

        // R8: reset request mode
        cur_req = "R8";
        rsel = 1'b1;
        service();
        measure(n, 100);
        chk(n == 6, "R8 delay", n, 6);
        chk(rstq == 1 && nmi == 0, "R8 reset request", int'(rstq), 1);
        @(negedge clk);
        chk(rstq == 0, "R7 reset pulse width", int'(rstq), 0);
        rsel = 1'b0;

        // R2: broken sequences do not reload
        cur_req = "R2";
        tmo = 16'd30;
        service();
        wr_key(16'h556C); wr_key(16'h1234); wr_key(16'hAA93); wr_key(16'hAA93);
        wr_key(16'h556C); wr_key(16'h556C); wr_key(16'hAA93);
        measure(n, 100);
        chk(n == 31 - 14, "R2 schedule unchanged", n, 17);

        // R4 + R1: disabled, pair accepted while disabled
        cur_req = "R4";
        en = 1'b0;
        tmo = 16'd3;
        service();
        count_pulses(p, 50);
        chk(p == 0, "R4 no pulses while disabled", p, 0);
        en = 1'b1;
        measure(n, 100);
        chk(n == 4, "R1 pair written while disabled", n, 4);

        // R5: freeze
        cur_req = "R5";
        fsel = 1'b1; frz = 1'b1;
        service();
        count_pulses(p, 40);
        chk(p == 0, "R5 frozen", p, 0);
        fsel = 1'b0;
        measure(n, 100);
        chk(n == 4, "R5 freeze ignored when not selected", n, 4);
        frz = 1'b0;

        // R6: prescaled
        cur_req = "R6";
        psel = 1'b1;
        tmo = 16'd2;
        service();
        measure(n, 10000);
        chk(n == exp_gap(2, 1), "R6 prescaled delay", n, exp_gap(2, 1));
        psel = 1'b0;

        // random mix against the model
        cur_req = "R7 random";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom % 16 == 0) tmo = 16'($urandom % 8);
            en   = ($urandom % 8) != 0;
            fsel = $urandom % 2;
            frz  = ($urandom % 4) == 0;
            rsel = $urandom % 2;
            wr   = ($urandom % 3) == 0;
            case ($urandom % 3)
                0: wdata = 16'h556C;
                1: wdata = 16'hAA93;
                default: wdata = 16'($urandom);
            endcase
        end
        @(negedge clk);
        wr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule